// File: doc/BRIEF.md
# Packed Dual-Halfword Integer ALU

This block is one lane of a SIMD integer datapath that treats every 32-bit source word as two independent 16-bit halves. In a single issue it computes one 16-bit result for the upper half of the destination and one for the lower half. Each of the two result slots picks its own operands: for every source, a select bit decides whether the upper or the lower half of that source feeds the slot, and a negate bit can flip the sign of the picked operand before the operation.

The operation comes from a 2-bit opcode. Add, subtract and low-half multiply use two sources. A fused multiply-add uses all three. A clamp input makes both slots saturate to the signed 16-bit range instead of wrapping. The packed result and its valid flag appear one clock after the request.

Top module: `pkhalf_alu`

## Requirements
- R1: For source k (0, 1, 2), bit k of a slot's pick field chooses that source's operand for the slot: 1 takes bits 31:16, 0 takes bits 15:0.
- R2: For source k, bit k of a slot's negate field replaces the picked operand with its two's complement before the operation.
- R3: The upper slot uses only `hiPick`/`hiNeg`, and the lower slot uses only `loPick`/`loNeg`. The output word is the upper-slot result in bits 31:16 and the lower-slot result in bits 15:0.
- R4: Opcode 0 adds (op0 + op1), 1 subtracts (op0 - op1), 2 returns the low 16 bits of op0 * op1, and 3 computes op0 * op1 + op2. All operands are signed 16-bit values.
- R5: For opcodes 0, 1 and 2, `src2` and bit 2 of both pick and negate fields have no effect on the result.
- R6: With `clampEn` low, each slot result wraps modulo 2^16.
- R7: With `clampEn` high, each slot result saturates to the range -32768..32767, in both slots.
- R8: Negating an operand of 0x8000 gives 0x8000 with `clampEn` low and 0x7FFF with `clampEn` high.
- R9: A request sampled with `inValid` high at a rising edge shows its result on `resWord` after that edge, and `resValid` equals `inValid` delayed by one cycle. Back-to-back requests each produce a result.
- R10: When `inValid` is low, `resWord` keeps its previous value.
- R11: While `rst` is high (synchronous), `resValid` and `resWord` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe |
| opSel | input | 2 | Operation code (0 add, 1 sub, 2 mul-low, 3 mul-add) |
| src0 | input | 32 | Source word 0 |
| src1 | input | 32 | Source word 1 |
| src2 | input | 32 | Source word 2 (multiply-add only) |
| hiPick | input | 3 | Per-source half select for the upper slot |
| loPick | input | 3 | Per-source half select for the lower slot |
| hiNeg | input | 3 | Per-source negate for the upper slot |
| loNeg | input | 3 | Per-source negate for the lower slot |
| clampEn | input | 1 | Signed saturation enable for both slots |
| resValid | output | 1 | Result valid, one cycle after the request |
| resWord | output | 32 | Packed result: upper slot in 31:16, lower slot in 15:0 |

## Verification
Two effects can act on the same slot in the same cycle: the operand negation, which has its own saturation of 0x8000, and the saturation of the operation's result. The bench provokes this by negating a 0x8000 operand with clamp set and adding a positive value, so that the saturated operand pushes the sum past the signed maximum. It then checks that the slot shows the result saturated a second time, not the wrapped value. In other vectors the upper and lower slots pick the same half of a source. There the bench checks that both halves of the output match its own model, and that the two halves are equal whenever the two slots' pick and negate fields are the same.

// File: rtl/pkhalf_pkg.sv
package pkhalf_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_MAD = 2'd3
  } pkOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  capture;
    pkOp_e op;
    logic  useThird;
    logic  sat;
  } pkCtrl_t;

endpackage

// File: rtl/pkhalf_ctrl.sv
module pkhalf_ctrl
  import pkhalf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] opSel,
  input  logic       clampEn,
  output pkCtrl_t    ctrl,
  output logic       resValid
);

  pkOp_e opDec;

  always_comb begin
    opDec         = pkOp_e'(opSel);
    ctrl.capture  = inValid;
    ctrl.op       = opDec;
    ctrl.useThird = (opDec == OP_MAD);
    ctrl.sat      = clampEn;
  end

  always_ff @(posedge clk) begin
    if (rst) resValid <= 1'b0;
    else     resValid <= inValid;
  end

endmodule

// File: rtl/pkhalf_lane.sv
module pkhalf_lane
  import pkhalf_pkg::*;
#(
  parameter int HW   = 16,
  parameter int NSRC = 3
) (
  input  logic [2*HW-1:0] srcWord [NSRC],
  input  logic [NSRC-1:0] pick,
  input  logic [NSRC-1:0] flip,
  input  pkCtrl_t         ctrl,
  output logic [HW-1:0]   halfRes
);

  localparam int WW = 2*HW + 1;
  localparam logic [HW-1:0] MIN_H = {1'b1, {(HW-1){1'b0}}};
  localparam logic [HW-1:0] MAX_H = {1'b0, {(HW-1){1'b1}}};
  localparam logic signed [WW-1:0] MAX_W = $signed({{(WW-HW){1'b0}}, MAX_H});
  localparam logic signed [WW-1:0] MIN_W = $signed({{(WW-HW){1'b1}}, MIN_H});

  logic [HW-1:0]          opnd [NSRC];
  logic signed [WW-1:0]   opW  [NSRC];
  logic signed [WW-1:0]   prod, wide;

  function automatic logic [HW-1:0] negHalf(input logic [HW-1:0] v, input logic sat);
    logic [HW-1:0] r;
    if (sat && v == MIN_H) r = MAX_H;
    else                   r = ~v + 1'b1;
    return r;
  endfunction

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic [HW-1:0] picked;
    assign picked  = pick[k] ? srcWord[k][2*HW-1:HW] : srcWord[k][HW-1:0];
    assign opnd[k] = flip[k] ? negHalf(picked, ctrl.sat) : picked;
    assign opW[k]  = $signed({{(WW-HW){opnd[k][HW-1]}}, opnd[k]});
  end

  assign prod = opW[0] * opW[1];

  always_comb begin
    unique case (ctrl.op)
      OP_ADD:  wide = opW[0] + opW[1];
      OP_SUB:  wide = opW[0] - opW[1];
      OP_MUL:  wide = prod;
      default: wide = prod + (ctrl.useThird ? opW[NSRC-1] : '0);
    endcase
  end

  always_comb begin
    if (ctrl.sat && wide > MAX_W)      halfRes = MAX_H;
    else if (ctrl.sat && wide < MIN_W) halfRes = MIN_H;
    else                               halfRes = wide[HW-1:0];
  end

endmodule

// File: rtl/pkhalf_dp.sv
module pkhalf_dp
  import pkhalf_pkg::*;
#(
  parameter int HW   = 16,
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  pkCtrl_t         ctrl,
  input  logic [2*HW-1:0] srcWord [NSRC],
  input  logic [NSRC-1:0] hiPick,
  input  logic [NSRC-1:0] loPick,
  input  logic [NSRC-1:0] hiNeg,
  input  logic [NSRC-1:0] loNeg,
  output logic [2*HW-1:0] resWord
);

  localparam int NSLOT = 2;

  logic [NSRC-1:0] slotPick [NSLOT];
  logic [NSRC-1:0] slotFlip [NSLOT];
  logic [HW-1:0]   slotRes  [NSLOT];

  assign slotPick[0] = loPick;
  assign slotPick[1] = hiPick;
  assign slotFlip[0] = loNeg;
  assign slotFlip[1] = hiNeg;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    pkhalf_lane #(.HW(HW), .NSRC(NSRC)) u_lane (
      .srcWord (srcWord),
      .pick    (slotPick[g]),
      .flip    (slotFlip[g]),
      .ctrl    (ctrl),
      .halfRes (slotRes[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)               resWord <= '0;
    else if (ctrl.capture) resWord <= {slotRes[1], slotRes[0]};
  end

endmodule

// File: rtl/pkhalf_alu.sv
module pkhalf_alu
  import pkhalf_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        opSel,
  input  logic [2*HALF_W-1:0] src0,
  input  logic [2*HALF_W-1:0] src1,
  input  logic [2*HALF_W-1:0] src2,
  input  logic [2:0]        hiPick,
  input  logic [2:0]        loPick,
  input  logic [2:0]        hiNeg,
  input  logic [2:0]        loNeg,
  input  logic              clampEn,
  output logic              resValid,
  output logic [2*HALF_W-1:0] resWord
);

  localparam int NSRC = 3;

  pkCtrl_t           ctrl;
  logic [2*HALF_W-1:0] srcWord [NSRC];

  assign srcWord[0] = src0;
  assign srcWord[1] = src1;
  assign srcWord[2] = src2;

  pkhalf_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opSel    (opSel),
    .clampEn  (clampEn),
    .ctrl     (ctrl),
    .resValid (resValid)
  );

  pkhalf_dp #(.HW(HALF_W), .NSRC(NSRC)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .srcWord (srcWord),
    .hiPick  (hiPick),
    .loPick  (loPick),
    .hiNeg   (hiNeg),
    .loNeg   (loNeg),
    .resWord (resWord)
  );

endmodule

// File: rtl/pkhalf_alu_chk.sv
module pkhalf_alu_chk #(
  parameter int HW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          inValid,
  input logic [2:0]    hiPick,
  input logic [2:0]    loPick,
  input logic [2:0]    hiNeg,
  input logic [2:0]    loNeg,
  input logic          resValid,
  input logic [2*HW-1:0] resWord
);

  logic outOfReset = 1'b0;
  always_ff @(posedge clk) outOfReset <= !rst;

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!resValid && resWord == '0));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    outOfReset |-> resValid == $past(inValid));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outOfReset && !$past(inValid)) |-> $stable(resWord));

  // R3
  slot_match_chk: assert property (@(posedge clk) disable iff (rst)
    (outOfReset && $past(inValid) && $past(hiPick) == $past(loPick)
      && $past(hiNeg) == $past(loNeg))
    |-> resWord[2*HW-1:HW] == resWord[HW-1:0]);

endmodule

bind pkhalf_alu pkhalf_alu_chk #(.HW(HALF_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .hiPick   (hiPick),
  .loPick   (loPick),
  .hiNeg    (hiNeg),
  .loNeg    (loNeg),
  .resValid (resValid),
  .resWord  (resWord)
);

// File: tb/test_pkhalf_alu.sv
`timescale 1ns/1ps
module test_pkhalf_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = '0;
  logic [31:0] src0 = '0, src1 = '0, src2 = '0;
  logic [2:0]  hiPick = '0, loPick = '0, hiNeg = '0, loNeg = '0;
  logic        clampEn = 1'b0;
  logic        resValid;
  logic [31:0] resWord;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pkhalf_alu i_pkhalf_alu (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .src0(src0), .src1(src1), .src2(src2),
    .hiPick(hiPick), .loPick(loPick), .hiNeg(hiNeg), .loNeg(loNeg),
    .clampEn(clampEn), .resValid(resValid), .resWord(resWord)
  );

  function automatic logic [15:0] refHalf(input logic [1:0] op,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
      input logic [2:0] pk, input logic [2:0] ng, input bit cl);
    logic [31:0] s [3];
    longint v [3];
    longint r;
    logic [15:0] h;
    s[0] = a; s[1] = b; s[2] = c;
    for (int k = 0; k < 3; k++) begin
      h = pk[k] ? s[k][31:16] : s[k][15:0];
      v[k] = longint'($signed(h));
      if (ng[k]) begin
        v[k] = -v[k];
        if (v[k] > 32767) v[k] = cl ? 32767 : -32768;
      end
    end
    case (op)
      2'd0: r = v[0] + v[1];
      2'd1: r = v[0] - v[1];
      2'd2: r = v[0] * v[1];
      default: r = v[0] * v[1] + v[2];
    endcase
    if (cl && r > 32767)  r = 32767;
    if (cl && r < -32768) r = -32768;
    return r[15:0];
  endfunction

  function automatic logic [31:0] refWord(input logic [1:0] op,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
      input logic [2:0] hp, input logic [2:0] lp, input logic [2:0] hn,
      input logic [2:0] ln, input bit cl);
    return {refHalf(op, a, b, c, hp, hn, cl), refHalf(op, a, b, c, lp, ln, cl)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drives at negedge, returns at the next negedge with the result visible
  task automatic issue(input logic [1:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] c, input logic [2:0] hp,
      input logic [2:0] lp, input logic [2:0] hn, input logic [2:0] ln,
      input bit cl, input bit keep);
    opSel = op; src0 = a; src1 = b; src2 = c;
    hiPick = hp; loPick = lp; hiNeg = hn; loNeg = ln; clampEn = cl;
    inValid = 1'b1;
    @(negedge clk);
    if (!keep) inValid = 1'b0;
  endtask

  task automatic runOne(input string tag, input logic [1:0] op,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
      input logic [2:0] hp, input logic [2:0] lp, input logic [2:0] hn,
      input logic [2:0] ln, input bit cl);
    issue(op, a, b, c, hp, lp, hn, ln, cl, 1'b0);
    chk(tag, resWord, refWord(op, a, b, c, hp, lp, hn, ln, cl));
  endtask

  task automatic tReset;
    chk("R11 valid in reset", {31'd0, resValid}, 32'd0);
    chk("R11 word in reset", resWord, 32'd0);
  endtask

  task automatic tSelect;
    // R1 R3: each slot chooses halves on its own
    runOne("R1 lo/lo add", 2'd0, 32'h0003_0010, 32'h0005_0020, 0, 3'b000, 3'b000, 0, 0, 0);
    chk("R1 literal", resWord, 32'h0030_0030);
    runOne("R1 hi/lo mix", 2'd0, 32'h0003_0010, 32'h0005_0020, 0, 3'b011, 3'b001, 0, 0, 0);
    chk("R3 packing literal", resWord, 32'h0008_0023);
    runOne("R3 swapped slots", 2'd1, 32'h1234_0100, 32'h0011_0022, 0, 3'b000, 3'b011, 0, 0, 0);
  endtask

  task automatic tNegate;
    runOne("R2 negate op0 hi slot", 2'd0, 32'h0000_0007, 32'h0000_0002, 0, 0, 0, 3'b001, 3'b000, 0);
    chk("R2 literal", resWord, 32'hFFFB_0009);
    runOne("R2 negate op1 both", 2'd1, 32'h0004_0004, 32'h0009_0009, 0, 3'b011, 0, 3'b010, 3'b010, 0);
  endtask

  task automatic tOps;
    runOne("R4 add", 2'd0, 32'h1111_2222, 32'h0101_0202, 0, 3'b011, 0, 0, 0, 0);
    runOne("R4 sub", 2'd1, 32'h0005_0003, 32'h0007_0001, 0, 3'b011, 0, 0, 0, 0);
    runOne("R4 mul", 2'd2, 32'h0003_FFFE, 32'h0007_0005, 0, 3'b011, 0, 0, 0, 0);
    chk("R4 mul literal", resWord, 32'h0015_FFF6);
    runOne("R4 mad", 2'd3, 32'h0003_0004, 32'h0005_0006, 32'h0010_0100, 3'b111, 0, 0, 3'b100, 0);
    chk("R4 mad literal", resWord, 32'h001F_FF18);
  endtask

  task automatic tThirdIgnored;
    logic [31:0] first;
    issue(2'd2, 32'h0009_0003, 32'h0002_0004, 32'h7777_1111, 3'b011, 0, 0, 0, 0, 1'b0);
    first = resWord;
    issue(2'd2, 32'h0009_0003, 32'h0002_0004, 32'hABCD_8000, 3'b111, 3'b100, 3'b100, 3'b100, 0, 1'b0);
    chk("R5 src2 no effect", resWord, first);
    chk("R5 value", resWord, 32'h0012_000C);
  endtask

  task automatic tWrap;
    runOne("R6 add wrap", 2'd0, 32'h7FFF_7FFF, 32'h0001_0001, 0, 0, 0, 0, 0, 0);
    chk("R6 literal", resWord, 32'h8000_8000);
    runOne("R6 mul wrap", 2'd2, 32'h0100_0180, 32'h0100_0100, 0, 3'b011, 0, 0, 0, 0);
    chk("R6 mul literal", resWord, 32'h0000_8000);
  endtask

  task automatic tClamp;
    runOne("R7 add sat both", 2'd0, 32'h7FFF_8000, 32'h0001_FFFF, 0, 3'b011, 0, 0, 0, 1);
    chk("R7 literal", resWord, 32'h7FFF_8000);
    runOne("R7 mul sat", 2'd2, 32'h0100_0100, 32'hFF00_0100, 0, 3'b011, 0, 0, 0, 1);
    chk("R7 mul literal", resWord, 32'h8000_7FFF);
  endtask

  task automatic tMinNeg;
    runOne("R8 neg min wrap", 2'd0, 32'h8000_8000, 32'h0, 0, 0, 0, 3'b001, 3'b001, 0);
    chk("R8 wrap literal", resWord, 32'h8000_8000);
    runOne("R8 neg min clamp", 2'd0, 32'h8000_8000, 32'h0, 0, 0, 0, 3'b001, 3'b001, 1);
    chk("R8 clamp literal", resWord, 32'h7FFF_7FFF);
    // double saturation: operand and result in one slot
    runOne("R8 R7 combined", 2'd0, 32'h8000_8000, 32'h0005_0005, 0, 0, 0, 3'b001, 3'b000, 1);
    chk("R8 R7 literal", resWord, 32'h7FFF_8005);
  endtask

  task automatic tTiming;
    issue(2'd0, 32'h0001_0001, 32'h0001_0001, 0, 0, 0, 0, 0, 0, 1'b1);
    chk("R9 valid first", {31'd0, resValid}, 32'd1);
    chk("R9 first result", resWord, 32'h0002_0002);
    issue(2'd1, 32'h0010_0010, 32'h0001_0003, 0, 3'b011, 0, 0, 0, 0, 1'b0);
    chk("R9 valid second", {31'd0, resValid}, 32'd1);
    chk("R9 second result", resWord, 32'h000F_000D);
    @(negedge clk);
    chk("R9 valid drops", {31'd0, resValid}, 32'd0);
  endtask

  task automatic tHold;
    logic [31:0] kept;
    runOne("R10 setup", 2'd2, 32'h0004_0006, 32'h0003_0002, 0, 3'b011, 0, 0, 0, 0);
    kept = resWord;
    src0 = 32'hDEAD_BEEF; src1 = 32'h1234_5678; opSel = 2'd0;
    repeat (3) @(negedge clk);
    chk("R10 hold", resWord, kept);
    chk("R10 valid low", {31'd0, resValid}, 32'd0);
  endtask

  task automatic tRandom;
    for (int i = 0; i < 60; i++) begin
      runOne("R1 R2 R4 R6 R7 random", 2'($urandom), $urandom, $urandom, $urandom,
             3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom), 1'($urandom));
    end
  endtask

  task automatic tResetMid;
    runOne("R11 setup", 2'd0, 32'h0001_0001, 32'h0001_0001, 0, 0, 0, 0, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    chk("R11 word cleared", resWord, 32'd0);
    chk("R11 valid cleared", {31'd0, resValid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rst = 1'b0;
    @(negedge clk);
    tSelect();
    tNegate();
    tOps();
    tThirdIgnored();
    tWrap();
    tClamp();
    tMinNeg();
    tTiming();
    tHold();
    tRandom();
    tResetMid();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule